// File: doc/BRIEF.md
# Ethernet Link LED Activity Controller

This block drives a single status LED for an Ethernet PHY port. It watches the negotiated link state (link up, speed code, duplex) and three single-cycle event inputs (transmit, receive and collision). It combines them under a 16-bit hardware pattern word, and it lets a 16-bit force word override the result. A 12-bit blink word configures two independent blink profiles. Each profile picks one of eight blink rates and one of eight on/off ratios.

Each blink period is cut into twelve equal slices, and the duty code sets how many of those slices the LED is lit. Slice lengths and the 10 ms activity stretch come from a system clock frequency parameter. A shared prescaler produces a base tick at twelve times the fastest blink rate. Every event input opens an activity window that lasts one stretch length and restarts on each new event. Pattern-driven blinking always uses profile 1. Only the force override can select profile 2.

Top module: `link_led_ctrl`

## Requirements
- R1: In `blink_cfg`, bits 11:6 hold profile 1 and bits 5:0 hold profile 2. Within each 6-bit profile, the upper three bits are the rate code and the lower three bits are the duty code.
- R2: For rate code k (0..7), the nominal rate is 2^(k+1) Hz. The blink period is exactly 12 * 2^(7-k) * (CLK_HZ / 3072) clock cycles.
- R3: Duty codes 0..7 light the LED for 6, 9, 3, 4, 8, 2, 10 and 1 of the twelve slices. The lit slices come first in each period.
- R4: `force_cfg` bit 15 enables the override, and the override takes priority over the pattern. Bits 14:13 select the output: 0 gives off, 1 gives on, 2 follows profile 2 and 3 follows profile 1.
- R5: `link_speed` is coded 0=10, 1=100, 2=1000, 3=2500 Mb/s. With link up, pattern bits 4, 5, 6 and 15 light the LED steadily for those speeds.
- R6: With link up, pattern bit 12 lights the LED at full duplex and pattern bit 11 lights it at half duplex.
- R7: With link up, pattern bits 0, 1, 2 and 14 make the LED follow profile 1 at 10, 100, 1000 and 2500 Mb/s.
- R8: Pattern bits 10 (TX), 9 (RX) and 3 (collision) make the LED follow profile 1 while the matching activity window is open. This blinking overrides the steady-on conditions. The LED returns to steady once the window closes.
- R9: Pattern bits 8 (TX) and 7 (RX) light the LED steadily while the matching activity window is open. A window lasts CLK_HZ/100 cycles, and a new event restarts it.
- R10: Activity blinking needs link up plus a matching speed or duplex enable in the pattern. Pattern bit 13 lifts that qualification.
- R11: `led_out` is registered and reads 0 in reset. It reflects its inputs one clock later.
- R12: When the link is down, every speed and duplex condition is false. With no override and pattern bits 13, 8 and 7 clear, the LED stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | Speed code: 0=10, 1=100, 2=1000, 3=2500 Mb/s |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_evt | input | 1 | Single-cycle transmit event |
| rx_evt | input | 1 | Single-cycle receive event |
| col_evt | input | 1 | Single-cycle collision event |
| pattern_cfg | input | 16 | Hardware pattern enables |
| force_cfg | input | 16 | Override enable and mode |
| blink_cfg | input | 12 | Two blink profiles |
| led_out | output | 1 | LED level, 1 = lit |

## Verification
The bench measures the rising-edge-to-rising-edge period and the lit time for every rate code and every duty code, on both profiles. This catches a swapped profile field, a wrong shift in the slice divider, or a duty table entry that is off by one slice. Window tests count lit cycles after one event and after a second event partway through. A stretch that is one cycle short, or that fails to restart, changes that count. Other tests check that activity blinking stays dark without link and without the qualifier bypass, and that blinking gives way to steady-on when the window closes. Each force mode is also driven against a pattern that would otherwise light the LED, so an override that loses priority shows at once.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

    localparam int unsigned SLICES_PER_PERIOD = 12;
    localparam int unsigned FASTEST_BLINK_HZ  = 256;
    localparam int unsigned STRETCH_PER_SEC   = 100;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_2500 = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        FRC_OFF    = 2'd0,
        FRC_ON     = 2'd1,
        FRC_PROF_B = 2'd2,
        FRC_PROF_A = 2'd3
    } force_mode_e;

    function automatic logic [3:0] duty_on_slices(input logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'd0:    n = 4'd6;
            3'd1:    n = 4'd9;
            3'd2:    n = 4'd3;
            3'd3:    n = 4'd4;
            3'd4:    n = 4'd8;
            3'd5:    n = 4'd2;
            3'd6:    n = 4'd10;
            default: n = 4'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt >= LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt >= LAST);

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen
    import led_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [5:0] prof,
    output logic       wave
);
    localparam int unsigned SW = $clog2(SLICES_PER_PERIOD);
    localparam logic [SW-1:0] SLICE_LAST = SW'(SLICES_PER_PERIOD - 1);

    typedef struct packed {
        logic [5:0]    cfg;
        logic [6:0]    sub;
        logic [SW-1:0] slice;
    } blink_state_t;

    blink_state_t st_d, st_q;
    logic [6:0] sub_lim;
    logic       restart;
    logic       advance;

    always_comb begin
        sub_lim = (7'd1 << (3'd7 - st_q.cfg[5:3])) - 7'd1;
        restart = (prof != st_q.cfg);
        advance = tick && (st_q.sub >= sub_lim);
        st_d    = st_q;
        if (restart) begin
            st_d.cfg   = prof;
            st_d.sub   = '0;
            st_d.slice = '0;
        end else if (tick) begin
            if (advance) begin
                st_d.sub   = '0;
                st_d.slice = (st_q.slice >= SLICE_LAST) ? '0 : st_q.slice + SW'(1);
            end else begin
                st_d.sub = st_q.sub + 7'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave = ({1'b0, st_q.slice} < 5'(duty_on_slices(st_q.cfg[2:0])));

    AST_SLICE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart && st_q.slice == SLICE_LAST) |=> (st_q.slice == '0)); // R2

    AST_RESTART_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> wave); // R3

endmodule

// File: rtl/led_act_window.sv
module led_act_window #(
    parameter int unsigned LEN = 61
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic open
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    typedef struct packed {
        logic [CW-1:0] remain;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt) begin
            st_d.remain = FULL;
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open = (st_q.remain != '0);

    AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (st_q.remain == FULL)); // R9

    AST_WIN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !open) |=> !open); // R9

endmodule

// File: rtl/link_led_ctrl.sv
module link_led_ctrl
    import led_ctrl_pkg::*;
#(
    parameter int unsigned CLK_HZ = 250_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic [1:0]  link_speed,
    input  logic        full_duplex,
    input  logic        tx_evt,
    input  logic        rx_evt,
    input  logic        col_evt,
    input  logic [15:0] pattern_cfg,
    input  logic [15:0] force_cfg,
    input  logic [11:0] blink_cfg,
    output logic        led_out
);
    localparam int unsigned BASE_DIV = CLK_HZ / (SLICES_PER_PERIOD * FASTEST_BLINK_HZ);
    localparam int unsigned STRETCH  = CLK_HZ / STRETCH_PER_SEC;
    localparam int unsigned NPROF    = 2;
    localparam int unsigned NCHAN    = 3;

    typedef struct packed {
        logic led;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             base_tick;
    logic [NPROF-1:0] wave;
    logic [NCHAN-1:0] evt_vec;
    logic [NCHAN-1:0] win_open;

    logic spd_on, spd_blink, dup_on, qualified, act_blink, steady, pat_led;
    force_mode_e fmode;

    led_tick_gen #(.DIV(BASE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (base_tick)
    );

    // index 0 -> profile 2 (bits 5:0), index 1 -> profile 1 (bits 11:6)
    generate
        for (genvar g = 0; g < NPROF; g++) begin : g_prof
            led_blink_gen u_blink (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (base_tick),
                .prof  (blink_cfg[g*6 +: 6]),
                .wave  (wave[g])
            );
        end
    endgenerate

    assign evt_vec = {col_evt, rx_evt, tx_evt};

    generate
        for (genvar c = 0; c < NCHAN; c++) begin : g_win
            led_act_window #(.LEN(STRETCH)) u_win (
                .clk   (clk),
                .rst_n (rst_n),
                .evt   (evt_vec[c]),
                .open  (win_open[c])
            );
        end
    endgenerate

    always_comb begin
        case (speed_e'(link_speed))
            SPD_10:   begin spd_on = pattern_cfg[4];  spd_blink = pattern_cfg[0];  end
            SPD_100:  begin spd_on = pattern_cfg[5];  spd_blink = pattern_cfg[1];  end
            SPD_1000: begin spd_on = pattern_cfg[6];  spd_blink = pattern_cfg[2];  end
            default:  begin spd_on = pattern_cfg[15]; spd_blink = pattern_cfg[14]; end
        endcase
        spd_on    = spd_on    && link_up;
        spd_blink = spd_blink && link_up;
        dup_on    = link_up && (full_duplex ? pattern_cfg[12] : pattern_cfg[11]);
        qualified = pattern_cfg[13] || spd_on || spd_blink || dup_on;
        act_blink = qualified && ((pattern_cfg[10] && win_open[0]) ||
                                  (pattern_cfg[9]  && win_open[1]) ||
                                  (pattern_cfg[3]  && win_open[2]));
        steady    = spd_on || dup_on ||
                    (pattern_cfg[8] && win_open[0]) ||
                    (pattern_cfg[7] && win_open[1]);
        pat_led   = (spd_blink || act_blink) ? wave[1] : steady;

        fmode = force_mode_e'(force_cfg[14:13]);
        st_d  = st_q;
        if (force_cfg[15]) begin
            case (fmode)
                FRC_OFF:    st_d.led = 1'b0;
                FRC_ON:     st_d.led = 1'b1;
                FRC_PROF_B: st_d.led = wave[0];
                default:    st_d.led = wave[1];
            endcase
        end else begin
            st_d.led = pat_led;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led_out = st_q.led;

    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cfg[15] && force_cfg[14:13] == 2'd0) |=> !led_out); // R4

    AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cfg[15] && force_cfg[14:13] == 2'd1) |=> led_out); // R4

    AST_NO_LINK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_cfg[15] && !link_up && !pattern_cfg[13] && !pattern_cfg[8] && !pattern_cfg[7])
        |=> !led_out); // R12

    AST_STEADY_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_cfg[15] && link_up && link_speed == 2'd2 && pattern_cfg[6] &&
         pattern_cfg[2:0] == 3'b000 && pattern_cfg[14] == 1'b0 &&
         pattern_cfg[10:9] == 2'b00 && pattern_cfg[3] == 1'b0) |=> led_out); // R5

endmodule

// File: tb/link_led_ctrl_tb.sv
module link_led_ctrl_tb;

    localparam int unsigned TB_CLK_HZ = 6144;
    localparam int unsigned UNIT      = TB_CLK_HZ / 3072;
    localparam int unsigned STRETCH   = TB_CLK_HZ / 100;
    localparam int unsigned WATCHDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic [1:0]  link_speed = 2'd0;
    logic        full_duplex = 1'b0;
    logic        tx_evt = 1'b0;
    logic        rx_evt = 1'b0;
    logic        col_evt = 1'b0;
    logic [15:0] pattern_cfg = '0;
    logic [15:0] force_cfg = '0;
    logic [11:0] blink_cfg = '0;
    logic        led_out;

    always #2 clk = ~clk;

    link_led_ctrl #(.CLK_HZ(TB_CLK_HZ)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_up     (link_up),
        .link_speed  (link_speed),
        .full_duplex (full_duplex),
        .tx_evt      (tx_evt),
        .rx_evt      (rx_evt),
        .col_evt     (col_evt),
        .pattern_cfg (pattern_cfg),
        .force_cfg   (force_cfg),
        .blink_cfg   (blink_cfg),
        .led_out     (led_out)
    );

    typedef struct {
        int    period;
        int    lit;
        string tag;
    } wave_exp_t;

    wave_exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    function automatic int slices_for(input int code);
        int t[8] = '{6, 9, 3, 4, 8, 2, 10, 1};
        return t[code];
    endfunction

    function automatic int unit_for(input int rate);
        return (1 << (7 - rate)) * UNIT;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: measures one full period after skipping a partial one
    initial begin
        forever begin
            int  hi;
            int  per;
            int  rises;
            logic prev;
            wave_exp_t e;
            while (exp_q.size() == 0) @(negedge clk);
            rises = 0;
            prev  = led_out;
            while (rises < 2) begin
                @(negedge clk);
                if (led_out && !prev) rises++;
                prev = led_out;
            end
            hi = 1;
            forever begin
                @(negedge clk);
                if (led_out) hi++;
                else break;
            end
            per = hi + 1;
            forever begin
                @(negedge clk);
                if (led_out) break;
                per++;
            end
            e = exp_q.pop_front();
            check(per == e.period, {e.tag, " period"}, per, e.period);
            check(hi == e.lit, {e.tag, " lit"}, hi, e.lit);
            done_cnt++;
        end
    end

    task automatic expect_wave(input int period, input int lit, input string tag);
        int target;
        wave_exp_t e;
        target   = done_cnt + 1;
        e.period = period;
        e.lit    = lit;
        e.tag    = tag;
        exp_q.push_back(e);
        while (done_cnt < target) @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_level(input logic expv, input string tag);
        settle();
        check(led_out == expv, tag, int'(led_out), int'(expv));
    endtask

    // ch: 0 tx, 1 rx; second event at iteration 'again' (-1 = none)
    task automatic count_lit(input int ch, input int again, input int n, output int hi, output int lo);
        hi = 0;
        lo = 0;
        if (ch == 0) tx_evt = 1'b1; else rx_evt = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (led_out) hi++; else lo++;
            if (ch == 0) tx_evt = (i == again); else rx_evt = (i == again);
        end
        tx_evt = 1'b0;
        rx_evt = 1'b0;
    endtask

    initial begin
        int c;
        c = 0;
        while (!finished) begin
            @(posedge clk);
            c++;
            if (c > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", c, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        int hi;
        int lo;
        repeat (4) @(negedge clk);
        check(led_out == 1'b0, "R11 reset level", int'(led_out), 0);
        rst_n = 1'b1;
        check_level(1'b0, "R11 idle after reset");

        // R2: every rate code via profile 1 (force mode 3), duty code 0
        force_cfg = 16'h8000 | (16'd3 << 13);
        for (int k = 0; k < 8; k++) begin
            blink_cfg = 12'((k << 9) | (0 << 6) | 6'o75);
            expect_wave(12 * unit_for(k), 6 * unit_for(k), $sformatf("R2 rate %0d", k));
        end

        // R3/R1: every duty code on profile 2 (force mode 2), profile 1 held elsewhere
        force_cfg = 16'h8000 | (16'd2 << 13);
        for (int d = 0; d < 8; d++) begin
            blink_cfg = 12'((6 << 9) | (0 << 6) | (7 << 3) | d);
            expect_wave(12 * unit_for(7), slices_for(d) * unit_for(7), $sformatf("R3 R1 prof2 duty %0d", d));
        end

        // R3: every duty code on profile 1 at rate 4
        force_cfg = 16'h8000 | (16'd3 << 13);
        for (int d = 0; d < 8; d++) begin
            blink_cfg = 12'((4 << 9) | (d << 6) | 6'o71);
            expect_wave(12 * unit_for(4), slices_for(d) * unit_for(4), $sformatf("R3 prof1 duty %0d", d));
        end

        // R4: force off beats a lit pattern; force on with link down
        link_up = 1'b1; link_speed = 2'd2; full_duplex = 1'b1;
        pattern_cfg = 16'h0040;
        force_cfg = 16'h8000;
        check_level(1'b0, "R4 force off");
        link_up = 1'b0; pattern_cfg = 16'h0000;
        force_cfg = 16'h8000 | (16'd1 << 13);
        check_level(1'b1, "R4 force on");
        force_cfg = 16'h0000;
        check_level(1'b0, "R4 override released");

        // R5: steady per speed
        link_up = 1'b1;
        pattern_cfg = 16'h8070;
        for (int s = 0; s < 4; s++) begin
            link_speed = 2'(s);
            check_level(1'b1, $sformatf("R5 speed %0d on", s));
        end
        pattern_cfg = 16'h0070; link_speed = 2'd3;
        check_level(1'b0, "R5 2500 not enabled");
        pattern_cfg = 16'h8000; link_speed = 2'd0;
        check_level(1'b0, "R5 10 not enabled");

        // R12: link down masks speed and duplex
        pattern_cfg = 16'h9870; link_up = 1'b0;
        check_level(1'b0, "R12 no link dark");

        // R6: duplex enables
        link_up = 1'b1; pattern_cfg = 16'h1000; full_duplex = 1'b1;
        check_level(1'b1, "R6 full duplex on");
        full_duplex = 1'b0;
        check_level(1'b0, "R6 half not enabled");
        pattern_cfg = 16'h0800;
        check_level(1'b1, "R6 half duplex on");

        // R7: speed blink follows profile 1
        blink_cfg = 12'((7 << 9) | (0 << 6) | 6'o05);
        pattern_cfg = 16'h0002; link_speed = 2'd1;
        expect_wave(12 * unit_for(7), 6 * unit_for(7), "R7 speed 100 blink");

        // R8: activity blink overrides steady, then steady returns
        pattern_cfg = 16'h0440; link_speed = 2'd2;
        check_level(1'b1, "R8 steady before activity");
        count_lit(0, -1, STRETCH - 6, hi, lo);
        check(lo > 0 && hi > 0, "R8 tx blink in window", lo, 1);
        repeat (20) @(negedge clk);
        check(led_out == 1'b1, "R8 steady after window", int'(led_out), 1);

        // R10: blink needs qualification unless bypass set
        link_up = 1'b0; pattern_cfg = 16'h0400;
        settle();
        count_lit(0, -1, STRETCH + 5, hi, lo);
        check(hi == 0, "R10 unqualified stays dark", hi, 0);
        pattern_cfg = 16'h2400;
        settle();
        count_lit(0, -1, STRETCH - 6, hi, lo);
        check(hi > 0 && lo > 0, "R10 bypass blinks", hi, 1);

        // R8: collision channel with qualification
        link_up = 1'b1; link_speed = 2'd0; pattern_cfg = 16'h0018;
        repeat (STRETCH + 5) @(negedge clk);
        col_evt = 1'b1;
        @(negedge clk);
        col_evt = 1'b0;
        lo = 0;
        for (int i = 0; i < STRETCH - 8; i++) begin
            @(negedge clk);
            if (!led_out) lo++;
        end
        check(lo > 0, "R8 collision blink", lo, 1);

        // R9: stretch length and restart
        link_up = 1'b0; pattern_cfg = 16'h0100;
        repeat (STRETCH + 5) @(negedge clk);
        count_lit(0, -1, STRETCH + 40, hi, lo);
        check(hi == STRETCH, "R9 tx stretch length", hi, STRETCH);
        pattern_cfg = 16'h0080;
        settle();
        count_lit(1, 29, 30 + STRETCH + 40, hi, lo);
        check(hi == 30 + STRETCH, "R9 rx stretch restart", hi, 30 + STRETCH);

        finish_run();
    end

endmodule